// File: doc/BRIEF.md
# One-Time-Programmable Memory Power and Read Sequencer

This block fronts a one-time-programmable word array and manages its power state. Three power modes exist: deep standby, standby and active. Software requests a mode by writing a code to the mode register. The block accepts the request only when it is the next legal step from the current mode. It then spends a fixed number of cycles on the step. When the step ends, the block sets a sticky status bit for that specific transition. Software polls the status register and clears the bit by writing a one to it.

In active mode, software reads a word in three steps. It writes a transfer count and a user word index, then writes the read code to the mode register. The block reads the word at the user region base plus the index from an array model, and sets the read-done status bit. The 32-bit word then sits in the data register. Throughout the read, the mode stays active.

The register bus has one write strobe and a shared address. Read data is registered: it reflects the register state one clock after the address is presented.

Top module: `otp_pwr_seq`

## Requirements
- R1: After synchronous reset, the mode register reads 0 (deep standby), the status register reads 0 and the data register reads 0.
- R2: The registers sit at these byte offsets: mode 0x2000, status 0x2008, word index 0x200C, read data 0x2010, transfer count 0x2020. The word index reads back the low log2(USER_WORDS) bits written. The transfer count reads back all 32 bits. Any other offset reads 0.
- R3: Mode codes are 0 deep standby, 1 standby, 2 active and 3 read. Only these requests are accepted: deep standby to standby, standby to active, standby to deep standby, and active to standby. Any other power request leaves the mode unchanged and sets no status bit. This includes a request for the current mode, deep standby straight to active, and active straight to deep standby.
- R4: An accepted step takes STEP_CYC clock edges. Until the step's status bit sets, the mode register reads the old mode. From the same edge that sets the bit, it reads the new mode.
- R5: Each step sets one status bit: bit 7 for standby to active, bit 8 for deep standby to standby, bit 9 for active to standby, bit 10 for standby to deep standby, and bit 0 for a finished read. All other bits read 0.
- R6: Status bits stay set until software writes 1 to their position. Writing 0 to a bit leaves it unchanged.
- R7: A mode write that arrives while a step or read is in progress is ignored.
- R8: A read code is accepted only in active mode and only when the transfer count is nonzero. Otherwise nothing happens and bit 0 stays clear.
- R9: A finished read loads the data register with the array word at index USER_BASE + i, where i is the word index register. Word n (n taken as 8 bits) holds {8'hC3, n, ~n, n ^ 8'h5A}. After the read the mode reads active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for bus_addr |
| bus_addr | input | BUS_AW | Byte offset for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
The bench sweeps every request code from each of the three power modes, so all legal and illegal steps are covered. A design that let deep standby jump straight to active, or that treated a same-mode write as a step, would show a wrong mode or a stray status bit. The bench also counts polling cycles to catch a step whose length is off by one. It sends a request in the middle of a step to catch a controller that retargets while busy. All 32 user words are read and compared with the arithmetic word formula; a wrong region base or a dropped address offset would fail on every word. Reads are also attempted with a zero transfer count and outside active mode. A design that started those reads would set bit 0 or change the data register.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [1:0] {
    PM_DEEP = 2'd0,
    PM_STBY = 2'd1,
    PM_ACT  = 2'd2,
    PM_READ = 2'd3
  } pm_t;

  localparam int OFS_MODE = 'h2000;
  localparam int OFS_STAT = 'h2008;
  localparam int OFS_IDX  = 'h200C;
  localparam int OFS_DATA = 'h2010;
  localparam int OFS_TCNT = 'h2020;

  localparam int ST_W     = 11;
  localparam int B_RD     = 0;
  localparam int B_S2A    = 7;
  localparam int B_D2S    = 8;
  localparam int B_A2S    = 9;
  localparam int B_S2D    = 10;
endpackage

// File: rtl/otp_word_rom.sv
module otp_word_rom #(
  parameter int ARR_AW = 8
) (
  input  logic              clk,
  input  logic [ARR_AW-1:0] addr,
  output logic [31:0]       dout
);
  function automatic logic [31:0] word_of(input logic [ARR_AW-1:0] a);
    logic [7:0] n;
    n = 8'(a);
    return {8'hC3, n, ~n, n ^ 8'h5A};
  endfunction

  always_ff @(posedge clk) begin
    dout <= word_of(addr);
  end
endmodule

// File: rtl/otp_mode_fsm.sv
module otp_mode_fsm
  import otp_seq_pkg::*;
#(
  parameter int STEP_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_code,
  input  logic       cnt_ok,
  output pm_t        mode_o,
  output logic       rd_start_o,
  output logic [4:0] ev_o      // {s2d, a2s, d2s, s2a, rd}
);
  localparam int CW = $clog2(STEP_CYC + 1);

  pm_t           cur_q, tgt_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  pm_t           req;
  logic          legal, accept, done;

  assign req = pm_t'(req_code);

  always_comb begin
    unique case (cur_q)
      PM_DEEP: legal = (req == PM_STBY);
      PM_STBY: legal = (req == PM_ACT) || (req == PM_DEEP);
      PM_ACT:  legal = (req == PM_STBY) || ((req == PM_READ) && cnt_ok);
      default: legal = 1'b0;
    endcase
  end

  assign accept = req_valid && !busy_q && legal;
  assign done   = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= PM_DEEP;
      tgt_q  <= PM_DEEP;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      tgt_q  <= req;
      busy_q <= 1'b1;
      cnt_q  <= CW'(STEP_CYC - 1);
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        if (tgt_q != PM_READ) cur_q <= tgt_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign mode_o     = cur_q;
  assign rd_start_o = accept && (req == PM_READ);
  assign ev_o[0]    = done && (tgt_q == PM_READ);
  assign ev_o[1]    = done && (cur_q == PM_STBY) && (tgt_q == PM_ACT);
  assign ev_o[2]    = done && (cur_q == PM_DEEP) && (tgt_q == PM_STBY);
  assign ev_o[3]    = done && (cur_q == PM_ACT)  && (tgt_q == PM_STBY);
  assign ev_o[4]    = done && (cur_q == PM_STBY) && (tgt_q == PM_DEEP);

  // R3
  deep_no_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q == PM_DEEP) |=> (cur_q != PM_ACT));
  // R3
  act_no_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q == PM_ACT) |=> (cur_q != PM_DEEP));
  // R8
  read_only_active_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && tgt_q == PM_READ) |-> (cur_q == PM_ACT));
  // R5
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ev_o));
  // R7
  target_held_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> $stable(tgt_q));
  // R4
  mode_held_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> $stable(cur_q));
endmodule

// File: rtl/otp_pwr_seq.sv
module otp_pwr_seq
  import otp_seq_pkg::*;
#(
  parameter int STEP_CYC    = 8,
  parameter int USER_BASE   = 224,
  parameter int USER_WORDS  = 32,
  parameter int ARRAY_WORDS = 256,
  parameter int BUS_AW      = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int IDX_W  = $clog2(USER_WORDS);
  localparam int ARR_AW = $clog2(ARRAY_WORDS);

  logic [IDX_W-1:0] idx_q, rd_idx_q;
  logic [31:0]      tcnt_q, data_q, rom_dout;
  logic [ST_W-1:0]  stat_q, set_vec, clr_vec;
  logic [4:0]       ev;
  logic             rd_start, wr_mode;
  logic [ARR_AW-1:0] rom_addr;
  pm_t              mode;

  assign wr_mode = bus_wr && (bus_addr == BUS_AW'(OFS_MODE));

  otp_mode_fsm #(.STEP_CYC(STEP_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (wr_mode),
    .req_code  (bus_wdata[1:0]),
    .cnt_ok    (tcnt_q != '0),
    .mode_o    (mode),
    .rd_start_o(rd_start),
    .ev_o      (ev)
  );

  assign rom_addr = ARR_AW'(USER_BASE) + ARR_AW'(rd_idx_q);

  otp_word_rom #(.ARR_AW(ARR_AW)) u_rom (
    .clk (clk),
    .addr(rom_addr),
    .dout(rom_dout)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[B_RD]  = ev[0];
    set_vec[B_S2A] = ev[1];
    set_vec[B_D2S] = ev[2];
    set_vec[B_A2S] = ev[3];
    set_vec[B_S2D] = ev[4];
    clr_vec = (bus_wr && bus_addr == BUS_AW'(OFS_STAT)) ? bus_wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      rd_idx_q <= '0;
      tcnt_q   <= '0;
      data_q   <= '0;
      stat_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | set_vec;
      if (bus_wr && bus_addr == BUS_AW'(OFS_IDX))  idx_q  <= bus_wdata[IDX_W-1:0];
      if (bus_wr && bus_addr == BUS_AW'(OFS_TCNT)) tcnt_q <= bus_wdata;
      if (rd_start) rd_idx_q <= idx_q;
      if (ev[0])    data_q   <= rom_dout;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        BUS_AW'(OFS_MODE): bus_rdata <= 32'(mode);
        BUS_AW'(OFS_STAT): bus_rdata <= 32'(stat_q);
        BUS_AW'(OFS_IDX):  bus_rdata <= 32'(idx_q);
        BUS_AW'(OFS_DATA): bus_rdata <= data_q;
        BUS_AW'(OFS_TCNT): bus_rdata <= tcnt_q;
        default:           bus_rdata <= '0;
      endcase
    end
  end

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_vec)) == $past(stat_q & ~clr_vec)));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && data_q == '0 && mode == PM_DEEP));
  // R9
  read_keeps_active_chk: assert property (@(posedge clk) disable iff (rst)
    ev[0] |=> (mode == PM_ACT));
endmodule

// File: tb/otp_pwr_seq_bench.sv
module otp_pwr_seq_bench;
  localparam int CLK_P = 10;
  localparam int STEP  = 8;
  localparam int BASE  = 224;
  localparam int NW    = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  otp_pwr_seq #(.STEP_CYC(STEP), .USER_BASE(BASE), .USER_WORDS(NW)) u_otp_pwr_seq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 14'(a); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 14'(a);
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] word_exp(input int n);
    logic [7:0] b;
    b = 8'(n);
    return {8'hC3, b, ~b, b ^ 8'h5A};
  endfunction

  task automatic goto(input int m);
    logic [31:0] cur;
    for (int k = 0; k < 4; k++) begin
      rd('h2000, cur);
      if (int'(cur) == m) break;
      if (int'(cur) == 0) wr('h2000, 1);
      else if (int'(cur) == 2) wr('h2000, 1);
      else wr('h2000, (m == 2) ? 2 : 0);
      idle(STEP + 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int exp_m, exp_s, polls;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    rd('h2000, v); chk("R1 mode after reset", v, 0);
    rd('h2008, v); chk("R1 status after reset", v, 0);
    rd('h2010, v); chk("R1 data after reset", v, 0);

    // R2 register readback
    wr('h200C, 32'h3F); rd('h200C, v); chk("R2 index readback", v, 32'h1F);
    wr('h2020, 32'hDEADBEEF); rd('h2020, v); chk("R2 count readback", v, 32'hDEADBEEF);
    rd('h2004, v); chk("R2 unmapped offset", v, 0);

    // R3 R5 sweep of every request from every power mode
    wr('h2020, 1);
    for (int s = 0; s < 3; s++) begin
      for (int r = 0; r < 4; r++) begin
        goto(s);
        wr('h2008, 32'h7FF);
        wr('h2000, 32'(r));
        idle(STEP + 3);
        exp_m = s; exp_s = 0;
        if (s == 0 && r == 1) begin exp_m = 1; exp_s = 1 << 8;  end
        if (s == 1 && r == 2) begin exp_m = 2; exp_s = 1 << 7;  end
        if (s == 1 && r == 0) begin exp_m = 0; exp_s = 1 << 10; end
        if (s == 2 && r == 1) begin exp_m = 1; exp_s = 1 << 9;  end
        if (s == 2 && r == 3) begin exp_s = 1; end
        rd('h2000, v); chk($sformatf("R3 mode from %0d req %0d", s, r), v, 32'(exp_m));
        rd('h2008, v); chk($sformatf("R5 status from %0d req %0d", s, r), v, 32'(exp_s));
      end
    end

    // R4 R7 old mode held mid-step, busy request ignored
    goto(0);
    wr('h2008, 32'h7FF);
    wr('h2000, 1);
    idle(STEP / 2 - 2);
    rd('h2000, v); chk("R4 old mode mid-step", v, 0);
    rd('h2008, v); chk("R4 no status mid-step", v, 0);
    wr('h2000, 2);
    idle(STEP + 3);
    rd('h2000, v); chk("R7 busy request ignored mode", v, 1);
    rd('h2008, v); chk("R7 busy request ignored status", v, 32'h100);

    // R4 exact step length: status seen on poll STEP+1
    wr('h2008, 32'h7FF);
    wr('h2000, 2);
    polls = 0;
    for (int k = 0; k < 4 * STEP; k++) begin
      rd('h2008, v); polls++;
      if (v[7]) break;
    end
    chk("R4 step length in polls", 32'(polls), 32'(STEP + 1));
    rd('h2000, v); chk("R4 new mode after step", v, 2);

    // R6 sticky and write-one-to-clear
    wr('h2008, 32'h0); rd('h2008, v); chk("R6 write zero keeps bit", v, 32'h80);
    wr('h2008, 32'h80); rd('h2008, v); chk("R6 write one clears", v, 0);

    // R9 read sweep over all user words
    for (int w = 0; w < NW; w++) begin
      wr('h200C, 32'(w));
      wr('h2008, 1);
      wr('h2000, 3);
      idle(STEP + 2);
      rd('h2008, v); chk($sformatf("R9 done bit word %0d", w), v, 1);
      rd('h2010, v); chk($sformatf("R9 data word %0d", w), v, word_exp(BASE + w));
      rd('h2000, v); chk($sformatf("R9 mode active word %0d", w), v, 2);
    end

    // R8 zero count blocks a read
    wr('h2008, 32'h7FF);
    wr('h2020, 0);
    wr('h200C, 0);
    wr('h2000, 3);
    idle(STEP + 3);
    rd('h2008, v); chk("R8 zero count no done bit", v, 0);
    rd('h2010, v); chk("R8 zero count data kept", v, word_exp(BASE + NW - 1));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule